// File: doc/BRIEF.md
# Audio Clock-Regeneration CTS Scheduler

This block decides when an audio clock-regeneration packet should be sent and which N and CTS values it carries. A downstream packet builder consumes the result over a valid/ready handshake. Packet encoding and insertion into the video stream happen outside this block. The block runs in the pixel clock domain and watches a one-cycle audio-bus sync pulse (`aud_sync`).

A packet opportunity arises once every N/128 sync pulses. In table mode, the CTS value alternates between two programmed 20-bit values. Each value is held for its own programmed number of period ticks, and a tick is either every pixel clock or every sync pulse, chosen by a configuration bit. In measured mode, the CTS value is the number of pixel clocks counted across the last N/128 sync pulses. A disable bit stops new packets. Every configuration write restarts the alternation.

Back-pressure follows the usual stream rules. Once `pkt_valid` rises, it stays high and `pkt_n`/`pkt_cts` stay unchanged until a cycle with `pkt_ready` high. A packet opportunity that arrives while a packet is still waiting is dropped. The alternation and the measurement keep running regardless.

Top module: `cts_regen_sched`

## Requirements
- R1: After reset the block is disabled: `pkt_valid` is low and stays low under sync pulses until a configuration with `cfg_disable` clear is written.
- R2: All configuration inputs are captured on a cycle with `cfg_wr` high and take effect from the next cycle.
- R3: While the captured `cfg_disable` is 1, no new packet is offered.
- R4: A packet opportunity occurs on every D-th sync pulse, where D = N >> 7 (N/128), and D = 1 when N < 128. `pkt_n` carries the captured N unchanged.
- R5: In table mode (`cfg_ext_cts` = 0), `pkt_cts` is CTS_0 for PERIOD_0 ticks, then CTS_1 for PERIOD_1 ticks, and so on. A period of 0 acts as 1. The packet carries the value in effect just before the sync pulse that completes it.
- R6: With `cfg_sync_tick` = 0, the period counter ticks on every clock. With `cfg_sync_tick` = 1, it ticks only on sync pulses.
- R7: In measured mode (`cfg_ext_cts` = 1), `pkt_cts` is the number of clock cycles in the window. The window starts the cycle after the previous completing pulse, or the cycle after a configuration write. It ends with the completing pulse's own cycle, inclusive. The count saturates at all ones.
- R8: While `pkt_valid` is 1 and `pkt_ready` is 0, `pkt_valid`, `pkt_n` and `pkt_cts` hold. Opportunities arriving meanwhile are dropped.
- R9: A configuration write restarts the schedule: CTS_0 is selected and the period, sync and cycle counters are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Capture all configuration inputs, restart schedule |
| cfg_sync_tick | input | 1 | 1: period ticks on sync pulses; 0: every clock |
| cfg_disable | input | 1 | 1: no packets offered |
| cfg_ext_cts | input | 1 | 1: measured CTS; 0: table CTS |
| cfg_n | input | 20 | N value |
| cts0_val | input | 20 | First table CTS value |
| cts1_val | input | 20 | Second table CTS value |
| period0_val | input | 20 | Ticks for which CTS_0 is used |
| period1_val | input | 20 | Ticks for which CTS_1 is used |
| aud_sync | input | 1 | One-cycle audio-bus sync pulse |
| pkt_ready | input | 1 | Packet consumer accepts |
| pkt_valid | output | 1 | Packet request pending |
| pkt_n | output | 20 | N of the pending packet |
| pkt_cts | output | 20 | CTS of the pending packet |

## Verification
The bench builds the block with the default widths: 20-bit CTS and N, and a divide shift of 7. N values of 100, 128, 200 and 256 then give sync dividers of 1, 1, 1 and 2. Packets therefore come within a handful of pulses, and the N < 128 floor and the floor of a non-multiple of 128 can both be reached. Short periods (0 to 3) make every alternation boundary reachable within a few cycles or pulses. A 10-cycle sync spacing makes the measured windows small enough to predict exactly, including the shorter first window after a configuration write.

// File: rtl/cts_regen_pkg.sv
`timescale 1ns/1ps
package cts_regen_pkg;
  localparam int DEF_CTS_W   = 20;
  localparam int DEF_N_W     = 20;
  localparam int DEF_N_SHIFT = 7;

  typedef enum logic {
    SRC_TABLE    = 1'b0,
    SRC_MEASURED = 1'b1
  } cts_src_e;
endpackage

// File: rtl/cts_alternator.sv
`timescale 1ns/1ps
module cts_alternator #(
  parameter int W = 20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         restart,
  input  logic         tick,
  input  logic [W-1:0] period0,
  input  logic [W-1:0] period1,
  input  logic [W-1:0] cts0,
  input  logic [W-1:0] cts1,
  output logic [W-1:0] cts_cur
);
  logic         sel_q;
  logic [W-1:0] pc_q;
  logic [W-1:0] raw_lim;
  logic [W-1:0] lim;
  logic [W:0]   pc_inc;

  always_comb begin
    raw_lim = sel_q ? period1 : period0;
    lim     = (raw_lim == '0) ? {{(W-1){1'b0}}, 1'b1} : raw_lim;
    pc_inc  = {1'b0, pc_q} + {{W{1'b0}}, 1'b1};
    cts_cur = sel_q ? cts1 : cts0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      sel_q <= 1'b0;
      pc_q  <= '0;
    end else if (tick) begin
      if (pc_inc >= {1'b0, lim}) begin
        pc_q  <= '0;
        sel_q <= ~sel_q;
      end else begin
        pc_q <= pc_inc[W-1:0];
      end
    end
  end

  a_r5_pc_below_limit: assert property (@(posedge clk) disable iff (!rst_n)
    pc_q < lim);
  a_r9_restart_to_first: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (!sel_q && pc_q == '0));
endmodule

// File: rtl/cts_sync_divider.sv
`timescale 1ns/1ps
module cts_sync_divider #(
  parameter int N_W     = 20,
  parameter int N_SHIFT = 7
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           restart,
  input  logic           sync,
  input  logic [N_W-1:0] n_val,
  output logic           done
);
  logic [N_W-1:0] div;
  logic [N_W-1:0] cnt_q;
  logic [N_W:0]   cnt_inc;

  always_comb begin
    div     = n_val >> N_SHIFT;
    if (div == '0) div = {{(N_W-1){1'b0}}, 1'b1};
    cnt_inc = {1'b0, cnt_q} + {{N_W{1'b0}}, 1'b1};
    done    = sync && !restart && (cnt_inc >= {1'b0, div});
  end

  always_ff @(posedge clk) begin
    if (!rst_n || restart) cnt_q <= '0;
    else if (sync) cnt_q <= done ? '0 : cnt_inc[N_W-1:0];
  end

  a_r4_count_below_div: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < div);
endmodule

// File: rtl/cts_meter.sv
`timescale 1ns/1ps
module cts_meter #(
  parameter int W = 20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         restart,
  input  logic         window_end,
  output logic [W-1:0] measured
);
  logic [W-1:0] pix_q;

  always_comb measured = (&pix_q) ? pix_q : pix_q + {{(W-1){1'b0}}, 1'b1};

  always_ff @(posedge clk) begin
    if (!rst_n || restart || window_end) pix_q <= '0;
    else pix_q <= measured;
  end

  a_r7_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (restart || window_end) |=> (measured == {{(W-1){1'b0}}, 1'b1}));
endmodule

// File: rtl/cts_regen_sched.sv
`timescale 1ns/1ps
module cts_regen_sched
  import cts_regen_pkg::*;
#(
  parameter int CTS_W   = DEF_CTS_W,
  parameter int N_W     = DEF_N_W,
  parameter int N_SHIFT = DEF_N_SHIFT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic             cfg_sync_tick,
  input  logic             cfg_disable,
  input  logic             cfg_ext_cts,
  input  logic [N_W-1:0]   cfg_n,
  input  logic [CTS_W-1:0] cts0_val,
  input  logic [CTS_W-1:0] cts1_val,
  input  logic [CTS_W-1:0] period0_val,
  input  logic [CTS_W-1:0] period1_val,
  input  logic             aud_sync,
  input  logic             pkt_ready,
  output logic             pkt_valid,
  output logic [N_W-1:0]   pkt_n,
  output logic [CTS_W-1:0] pkt_cts
);
  logic             sync_tick_q, off_q;
  cts_src_e         src_q;
  logic [N_W-1:0]   n_q;
  logic [CTS_W-1:0] c0_q, c1_q, p0_q, p1_q;
  logic             tick, win_done, offer, can_load;
  logic [CTS_W-1:0] table_cts, meas_cts, chosen_cts;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_tick_q <= 1'b0;
      off_q       <= 1'b1;
      src_q       <= SRC_TABLE;
      n_q         <= '0;
      c0_q        <= '0;
      c1_q        <= '0;
      p0_q        <= '0;
      p1_q        <= '0;
    end else if (cfg_wr) begin
      sync_tick_q <= cfg_sync_tick;
      off_q       <= cfg_disable;
      src_q       <= cfg_ext_cts ? SRC_MEASURED : SRC_TABLE;
      n_q         <= cfg_n;
      c0_q        <= cts0_val;
      c1_q        <= cts1_val;
      p0_q        <= period0_val;
      p1_q        <= period1_val;
    end
  end

  always_comb tick = !cfg_wr && (sync_tick_q ? aud_sync : 1'b1);

  cts_alternator #(.W(CTS_W)) u_alt (
    .clk(clk), .rst_n(rst_n), .restart(cfg_wr), .tick(tick),
    .period0(p0_q), .period1(p1_q), .cts0(c0_q), .cts1(c1_q),
    .cts_cur(table_cts)
  );

  cts_sync_divider #(.N_W(N_W), .N_SHIFT(N_SHIFT)) u_div (
    .clk(clk), .rst_n(rst_n), .restart(cfg_wr), .sync(aud_sync),
    .n_val(n_q), .done(win_done)
  );

  cts_meter #(.W(CTS_W)) u_meter (
    .clk(clk), .rst_n(rst_n), .restart(cfg_wr), .window_end(win_done),
    .measured(meas_cts)
  );

  always_comb begin
    chosen_cts = (src_q == SRC_MEASURED) ? meas_cts : table_cts;
    offer      = win_done && !off_q;
    can_load   = !pkt_valid || pkt_ready;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pkt_valid <= 1'b0;
      pkt_n     <= '0;
      pkt_cts   <= '0;
    end else if (offer && can_load) begin
      pkt_valid <= 1'b1;
      pkt_n     <= n_q;
      pkt_cts   <= chosen_cts;
    end else if (pkt_ready) begin
      pkt_valid <= 1'b0;
    end
  end

  a_r8_hold_until_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && !pkt_ready) |=> (pkt_valid && $stable(pkt_n) && $stable(pkt_cts)));
  a_r3_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (off_q && !cfg_wr && !pkt_valid) |=> !pkt_valid);
endmodule

// File: tb/cts_regen_sched_test.sv
`timescale 1ns/1ps
module cts_regen_sched_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0, cfg_sync_tick = 1'b0, cfg_disable = 1'b0, cfg_ext_cts = 1'b0;
  logic [19:0] cfg_n = '0, cts0_val = '0, cts1_val = '0, period0_val = '0, period1_val = '0;
  logic        aud_sync = 1'b0, pkt_ready = 1'b1;
  logic        pkt_valid;
  logic [19:0] pkt_n, pkt_cts;

  int tests = 0, fails = 0;
  int cyc = 0, base = 0;
  bit finished = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  cts_regen_sched uut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sync_tick(cfg_sync_tick),
    .cfg_disable(cfg_disable), .cfg_ext_cts(cfg_ext_cts), .cfg_n(cfg_n),
    .cts0_val(cts0_val), .cts1_val(cts1_val), .period0_val(period0_val),
    .period1_val(period1_val), .aud_sync(aud_sync), .pkt_ready(pkt_ready),
    .pkt_valid(pkt_valid), .pkt_n(pkt_n), .pkt_cts(pkt_cts)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // value selector expected before tick k: CTS_0 for P0 ticks, CTS_1 for P1 ticks
  function automatic int exp_sel(int k, int p0, int p1);
    int a = (p0 == 0) ? 1 : p0;
    int b = (p1 == 0) ? 1 : p1;
    int r = k % (a + b);
    return (r < a) ? 0 : 1;
  endfunction

  task automatic do_cfg(input bit st, input bit dis, input bit ext, input int n,
                        input int c0, input int c1, input int p0, input int p1);
    @(negedge clk);
    cfg_sync_tick = st; cfg_disable = dis; cfg_ext_cts = ext; cfg_n = 20'(n);
    cts0_val = 20'(c0); cts1_val = 20'(c1); period0_val = 20'(p0); period1_val = 20'(p1);
    cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
    base = cyc;
  endtask

  task automatic pulse_at(input int k);
    while (cyc - base < k) @(negedge clk);
    aud_sync = 1'b1;
    @(negedge clk);
    aud_sync = 1'b0;
  endtask

  task automatic t_reset();
    chk(pkt_valid == 1'b0, "R1 reset valid", pkt_valid, 0);
    base = cyc;
    pulse_at(2);
    chk(pkt_valid == 1'b0, "R1 disabled after reset", pkt_valid, 0);
  endtask

  task automatic t_disable();
    do_cfg(1, 1, 0, 128, 5, 6, 1, 1);
    pulse_at(1);
    chk(pkt_valid == 1'b0, "R3 disable pulse1", pkt_valid, 0);
    pulse_at(3);
    chk(pkt_valid == 1'b0, "R3 disable pulse2", pkt_valid, 0);
  endtask

  task automatic t_sync_alt();
    // sync ticks, P0=2 P1=1
    do_cfg(1, 0, 0, 128, 'h100, 'h200, 2, 1);
    for (int i = 0; i < 6; i++) begin
      pulse_at(2 * i + 1);
      chk(pkt_valid == 1'b1, "R6 sync tick valid", pkt_valid, 1);
      chk(pkt_cts == (exp_sel(i, 2, 1) ? 'h200 : 'h100), "R5 R6 sync alternation",
          pkt_cts, exp_sel(i, 2, 1) ? 'h200 : 'h100);
    end
  endtask

  task automatic t_zero_period();
    do_cfg(1, 0, 0, 128, 7, 9, 0, 0);
    for (int i = 0; i < 4; i++) begin
      pulse_at(2 * i + 1);
      chk(pkt_cts == ((i % 2) ? 9 : 7), "R5 zero period acts as one", pkt_cts, (i % 2) ? 9 : 7);
    end
  endtask

  task automatic t_pixel_tick();
    int ks[4] = '{1, 4, 5, 9};
    do_cfg(0, 0, 0, 128, 'h11, 'h22, 3, 2);
    foreach (ks[j]) begin
      pulse_at(ks[j]);
      chk(pkt_cts == (exp_sel(ks[j], 3, 2) ? 'h22 : 'h11), "R6 pixel tick alternation",
          pkt_cts, exp_sel(ks[j], 3, 2) ? 'h22 : 'h11);
    end
  endtask

  task automatic t_divider();
    do_cfg(1, 0, 0, 256, 3, 4, 1, 1);
    pulse_at(1);
    chk(pkt_valid == 1'b0, "R4 N=256 first pulse no packet", pkt_valid, 0);
    pulse_at(3);
    chk(pkt_valid == 1'b1, "R4 N=256 second pulse packet", pkt_valid, 1);
    chk(pkt_n == 256, "R4 pkt_n", pkt_n, 256);
    do_cfg(1, 0, 0, 100, 3, 4, 1, 1);
    pulse_at(1);
    chk(pkt_valid == 1'b1 && pkt_n == 100, "R4 N<128 divides by one", pkt_n, 100);
    do_cfg(1, 0, 0, 200, 3, 4, 1, 1);
    pulse_at(1);
    chk(pkt_valid == 1'b1 && pkt_n == 200, "R4 N=200 divides by one", pkt_n, 200);
  endtask

  task automatic t_measured();
    do_cfg(0, 0, 1, 256, 1, 2, 1, 1);
    pulse_at(4);
    chk(pkt_valid == 1'b0, "R7 no packet mid window", pkt_valid, 0);
    pulse_at(14);
    chk(pkt_valid == 1'b1 && pkt_cts == 15, "R7 first window", pkt_cts, 15);
    chk(pkt_n == 256, "R7 n carried", pkt_n, 256);
    pulse_at(24);
    chk(pkt_valid == 1'b0, "R7 accepted then idle", pkt_valid, 0);
    pulse_at(34);
    chk(pkt_valid == 1'b1 && pkt_cts == 20, "R7 steady window", pkt_cts, 20);
  endtask

  task automatic t_backpressure();
    do_cfg(1, 0, 0, 128, 'h11, 'h22, 1, 1);
    pkt_ready = 1'b0;
    pulse_at(2);
    chk(pkt_valid == 1'b1 && pkt_cts == 'h11, "R8 first packet", pkt_cts, 'h11);
    pulse_at(5);
    chk(pkt_valid == 1'b1, "R8 valid held", pkt_valid, 1);
    chk(pkt_cts == 'h11, "R8 cts held, second dropped", pkt_cts, 'h11);
    pkt_ready = 1'b1;
    @(negedge clk);
    chk(pkt_valid == 1'b0, "R8 accepted", pkt_valid, 0);
    pulse_at(9);
    chk(pkt_cts == 'h11, "R8 alternation kept running", pkt_cts, 'h11);
  endtask

  task automatic t_restart();
    do_cfg(1, 0, 0, 128, 'h31, 'h32, 1, 1);
    pulse_at(1);
    chk(pkt_cts == 'h31, "R9 before restart", pkt_cts, 'h31);
    do_cfg(1, 0, 0, 128, 'h31, 'h32, 1, 1);
    pulse_at(1);
    chk(pkt_cts == 'h31, "R9 R2 restart returns to CTS_0", pkt_cts, 'h31);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_disable();
    t_sync_alt();
    t_zero_period();
    t_pixel_tick();
    t_divider();
    t_measured();
    t_backpressure();
    t_restart();
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule